// File: doc/BRIEF.md
# Serial-to-Parallel Packet Receiver with Line Decoding

This block sits between a recovered serial bit stream and a link-layer packet engine. Every cycle it sees the two raw bus levels. A strobe marks the cycles that carry a new bit time. The block hunts for the start-of-packet pattern and turns line transitions back into data bits. It removes the zero bits the sender inserts after long runs of ones, and it flags a run that breaks that rule. It recognises the end-of-packet signalling and packs the surviving payload bits into bytes or into 16-bit words.

The receive side shows a packet envelope (`rx_active`), a one-cycle strobe for each completed word (`rx_valid`), an error flag and, in wide mode, a flag that tells a full word from a final half word. The current bus condition is also reported as a registered two-bit code. The sync pattern and the end-of-packet symbols never reach the data output.

Top module: `usb_rx_deser`

## Requirements
- R1: `line_code` equals `{line_dm, line_dp}`, registered one clock later: 00 = SE0, 01 = J (dp high), 10 = K (dm high), 11 = SE1. It is updated every clock, strobed or not.
- R2: Outside a packet, a strobed J/K run of at least three decoded zeros followed by a decoded one starts a packet. A transition decodes as 0 and a repeated level as 1. `rx_active` rises on the clock edge of that final strobe. Fewer than three zeros before the one starts nothing.
- R3: Payload bits are NRZI-decoded and assembled least significant bit first. Each byte on `rx_data` equals the byte the sender encoded.
- R4: After six consecutive decoded payload ones, the next bit, when it is zero, is discarded. The run counter restarts on any zero and at the start of each packet.
- R5: A decoded one after six consecutive payload ones sets `rx_error` on that strobe's clock edge. No further words are delivered. `rx_error` stays high until the next SE0-then-J, where `rx_error` and `rx_active` both drop on the same edge.
- R6: `rx_valid` is a single-cycle pulse, only while `rx_active` is high, one for each completed word. In narrow mode (`wide_mode` = 0) a word is 8 bits, `rx_data[15:8]` is zero and `rx_validh` is 0.
- R7: In wide mode a word is 16 bits: the first received byte is in `rx_data[7:0]`, the second in `[15:8]`, and `rx_validh` is 1.
- R8: In wide mode, if exactly 8 payload bits are pending at end of packet, they are delivered with `rx_validh` = 0 and `rx_data[15:8]` = 0 on the edge of the closing J strobe. `rx_active` falls on the next edge.
- R9: End of packet is one or more SE0 strobes followed by a J strobe. Without a pending half word, `rx_active` falls on that J strobe's edge. Leftover bits that do not fill a byte are dropped.
- R10: A synchronous active-high reset clears `rx_active`, `rx_valid` and `rx_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | High for one clock per recovered bit time |
| line_dp | input | 1 | Recovered positive data line level |
| line_dm | input | 1 | Recovered negative data line level |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = bytes; held stable during a packet |
| rx_active | output | 1 | Packet envelope |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a completed word |
| rx_validh | output | 1 | Wide mode: upper byte of `rx_data` is valid |
| rx_error | output | 1 | Bit-stuffing violation in the current packet |
| rx_data | output | 16 | Received word |
| line_code | output | 2 | Registered bus condition code |

## Verification
A decoder holding the wrong previous line level inverts one bit of the next word, so the error shows in the very next `rx_valid` data. A run counter that is off by one either lets a stuffed zero through, which shifts every later bit of the packet, or raises `rx_error` on legal data. Both show within the packet in which they happen. A bit index that is not cleared at packet boundaries misaligns the first word of the following packet. A wrong end-of-packet path moves the falling edge of `rx_active` away from the J strobe, or away from the cycle after the half-word strobe, by at least one clock.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DRAIN = 2'd2
  } rx_state_e;

  // {dm, dp}
  localparam logic [1:0] LINE_SE0 = 2'b00;
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
  localparam logic [1:0] LINE_SE1 = 2'b11;
endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi
  import usb_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic       dp,
  input  logic       dm,
  output logic [1:0] line_code,
  output logic       sym_data,
  output logic       sym_se0,
  output logic       sym_j,
  output logic       dec_bit
);
  logic [1:0] raw;
  logic       prev_dp;

  assign raw      = {dm, dp};
  assign sym_data = strobe && ((raw == LINE_J) || (raw == LINE_K));
  assign sym_se0  = strobe && (raw == LINE_SE0);
  assign sym_j    = strobe && (raw == LINE_J);
  // repeated level decodes as one, a transition as zero
  assign dec_bit  = (dp == prev_dp);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_code <= LINE_SE0;
      prev_dp   <= 1'b1;
    end else begin
      line_code <= raw;
      if (sym_data)     prev_dp <= dp;
      else if (sym_se0) prev_dp <= 1'b1;  // bus returns to idle J after SE0
    end
  end
endmodule

// File: rtl/usb_rx_unstuff.sv
module usb_rx_unstuff #(
  parameter int RUN_MAX = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic in_valid,
  input  logic in_bit,
  output logic keep,
  output logic err
);
  localparam int CW = $clog2(RUN_MAX + 1);

  logic [CW-1:0] run;
  logic          at_max;

  assign at_max = (run == CW'(RUN_MAX));
  assign keep   = in_valid && !at_max;
  assign err    = in_valid && at_max && in_bit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run <= '0;
    end else if (in_valid) begin
      if (!in_bit)     run <= '0;
      else if (!at_max) run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/usb_rx_pack.sv
module usb_rx_pack #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                wide,
  input  logic                in_valid,
  input  logic                in_bit,
  input  logic                flush,
  output logic                half_ready,
  output logic                word_valid,
  output logic                word_full,
  output logic [2*BYTE_W-1:0] word_data
);
  localparam int WW = 2 * BYTE_W;
  localparam int IW = $clog2(WW);

  logic [WW-1:0] shreg;
  logic [WW-1:0] merged;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;

  assign last_idx   = wide ? IW'(WW - 1) : IW'(BYTE_W - 1);
  assign half_ready = wide && (idx == IW'(BYTE_W));

  always_comb begin
    merged      = shreg;
    merged[idx] = in_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      idx        <= '0;
      word_valid <= 1'b0;
      word_full  <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (clr) begin
        idx <= '0;
      end else if (flush) begin
        idx <= '0;
        if (half_ready) begin
          word_valid <= 1'b1;
          word_full  <= 1'b0;
          word_data  <= {{BYTE_W{1'b0}}, shreg[BYTE_W-1:0]};
        end
      end else if (in_valid) begin
        if (idx == last_idx) begin
          idx        <= '0;
          word_valid <= 1'b1;
          word_full  <= wide;
          word_data  <= wide ? merged : {{BYTE_W{1'b0}}, merged[BYTE_W-1:0]};
        end else begin
          shreg <= merged;
          idx   <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
  import usb_rx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int STUFF_RUN  = 6,
  parameter int SYNC_ZEROS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_strobe,
  input  logic                line_dp,
  input  logic                line_dm,
  input  logic                wide_mode,
  output logic                rx_active,
  output logic                rx_valid,
  output logic                rx_validh,
  output logic                rx_error,
  output logic [2*BYTE_W-1:0] rx_data,
  output logic [1:0]          line_code
);
  localparam int ZW = $clog2(SYNC_ZEROS + 1);

  rx_state_e     state;
  logic [ZW-1:0] zcnt;
  logic          seen_se0;
  logic          end_pend;

  logic sym_data, sym_se0, sym_j, dec_bit;
  logic recv, data_bit_v, eop;
  logic keep, stuff_err, half_ready;

  assign recv       = (state == ST_RECV);
  assign data_bit_v = recv && sym_data && !seen_se0;
  assign eop        = recv && seen_se0 && sym_j;

  usb_rx_nrzi u_nrzi (
    .clk       (clk),
    .rst       (rst),
    .strobe    (bit_strobe),
    .dp        (line_dp),
    .dm        (line_dm),
    .line_code (line_code),
    .sym_data  (sym_data),
    .sym_se0   (sym_se0),
    .sym_j     (sym_j),
    .dec_bit   (dec_bit)
  );

  usb_rx_unstuff #(.RUN_MAX(STUFF_RUN)) u_unstuff (
    .clk      (clk),
    .rst      (rst),
    .clr      (!recv),
    .in_valid (data_bit_v),
    .in_bit   (dec_bit),
    .keep     (keep),
    .err      (stuff_err)
  );

  usb_rx_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .clr        (!recv),
    .wide       (wide_mode),
    .in_valid   (keep),
    .in_bit     (dec_bit),
    .flush      (eop),
    .half_ready (half_ready),
    .word_valid (rx_valid),
    .word_full  (rx_validh),
    .word_data  (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      zcnt      <= '0;
      seen_se0  <= 1'b0;
      end_pend  <= 1'b0;
      rx_active <= 1'b0;
      rx_error  <= 1'b0;
    end else begin
      end_pend <= 1'b0;
      if (end_pend) rx_active <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (sym_se0) begin
            zcnt <= '0;
          end else if (sym_data) begin
            if (!dec_bit) begin
              if (zcnt != ZW'(SYNC_ZEROS)) zcnt <= zcnt + 1'b1;
            end else begin
              zcnt <= '0;
              if (zcnt == ZW'(SYNC_ZEROS)) begin
                state     <= ST_RECV;
                rx_active <= 1'b1;
                seen_se0  <= 1'b0;
              end
            end
          end
        end
        ST_RECV: begin
          if (sym_se0) seen_se0 <= 1'b1;
          if (eop) begin
            state    <= ST_HUNT;
            seen_se0 <= 1'b0;
            if (half_ready) end_pend  <= 1'b1;
            else            rx_active <= 1'b0;
          end else if (stuff_err) begin
            rx_error <= 1'b1;
            state    <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (sym_se0) begin
            seen_se0 <= 1'b1;
          end else if (sym_j && seen_se0) begin
            state     <= ST_HUNT;
            seen_se0  <= 1'b0;
            rx_active <= 1'b0;
            rx_error  <= 1'b0;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/usb_rx_deser_chk.sv
module usb_rx_deser_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                line_dp,
  input logic                line_dm,
  input logic                wide_mode,
  input logic                rx_active,
  input logic                rx_valid,
  input logic                rx_validh,
  input logic                rx_error,
  input logic [2*BYTE_W-1:0] rx_data,
  input logic [1:0]          line_code
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  assert_line_code_R1: assert property (@(posedge clk) disable iff (rst)
    seen |-> (line_code == $past({line_dm, line_dp})));

  assert_valid_in_pkt_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_active);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_narrow_word_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !wide_mode) |-> (!rx_validh && (rx_data[2*BYTE_W-1:BYTE_W] == '0)));

  assert_half_last_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && wide_mode && !rx_validh) |=> !rx_active);

  assert_err_in_pkt_R5: assert property (@(posedge clk) disable iff (rst)
    rx_error |-> rx_active);

  assert_err_no_data_R5: assert property (@(posedge clk) disable iff (rst)
    rx_error |-> !rx_valid);

  assert_err_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_active) |-> !rx_error);
endmodule

bind usb_rx_deser usb_rx_deser_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/usb_rx_deser_tb.sv
`timescale 1ns/1ps
module usb_rx_deser_tb;
  localparam logic [1:0] C_SE0 = 2'b00;
  localparam logic [1:0] C_J   = 2'b01;
  localparam logic [1:0] C_K   = 2'b10;

  logic clk = 1'b0, rst = 1'b1, strobe = 1'b0, dp = 1'b1, dm = 1'b0, wide = 1'b0;
  logic rx_active, rx_valid, rx_validh, rx_error;
  logic [15:0] rx_data;
  logic [1:0]  line_code;

  usb_rx_deser u_dut (
    .clk(clk), .rst(rst), .bit_strobe(strobe), .line_dp(dp), .line_dm(dm),
    .wide_mode(wide), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_validh(rx_validh), .rx_error(rx_error), .rx_data(rx_data),
    .line_code(line_code)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  logic [15:0] got_data [0:2047];
  logic        got_h    [0:2047];
  int          got_n = 0;
  int          last_valid_cyc = -1, fall_cyc = -1;
  logic        prev_active = 1'b0;
  always @(negedge clk) begin
    if (rx_valid && got_n < 2048) begin
      got_data[got_n] = rx_data;
      got_h[got_n]    = rx_validh;
      got_n           = got_n + 1;
      last_valid_cyc  = cyc;
    end
    if (prev_active && !rx_active) fall_cyc = cyc;
    prev_active = rx_active;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  int last_strobe_cyc = 0;
  task automatic sym(input logic [1:0] code);
    @(negedge clk);
    {dm, dp} = code;
    strobe   = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    last_strobe_cyc = cyc;
    repeat (2) @(negedge clk);
  endtask

  // sender model
  logic lvl = 1'b1;
  int   ones = 0;
  task automatic tx_raw(input logic b);
    if (!b) lvl = ~lvl;
    sym(lvl ? C_J : C_K);
  endtask
  task automatic tx_bit(input logic b);
    tx_raw(b);
    if (b) ones++; else ones = 0;
    if (ones == 6) begin
      tx_raw(1'b0);
      ones = 0;
    end
  endtask
  task automatic tx_sync();
    lvl = 1'b1;
    for (int i = 0; i < 7; i++) tx_raw(1'b0);
    tx_raw(1'b1);
    ones = 0;
  endtask
  int eop_cyc = 0;
  task automatic tx_eop();
    sym(C_SE0);
    sym(C_SE0);
    sym(C_J);
    eop_cyc = last_strobe_cyc;
    lvl = 1'b1;
    sym(C_J);
    sym(C_J);
  endtask

  logic [7:0] pkt [0:7];
  task automatic run_pkt(input int n, input int dribble);
    int base, nexp;
    bit half;
    base = got_n;
    tx_sync();
    check(rx_active === 1'b1, "R2 active after sync", {31'd0, rx_active}, 1);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) tx_bit(pkt[i][k]);
    for (int d = 0; d < dribble; d++) tx_bit(1'b0);
    tx_eop();
    half = wide && (n % 2 == 1);
    nexp = wide ? (n + 1) / 2 : n;
    check(got_n - base == nexp, wide ? "R7 word count" : "R6 word count", got_n - base, nexp);
    for (int j = 0; j < nexp && j < got_n - base; j++) begin
      logic [15:0] ed;
      logic        eh;
      if (!wide) begin
        ed = {8'h00, pkt[j]}; eh = 1'b0;
      end else if (half && j == nexp - 1) begin
        ed = {8'h00, pkt[2*j]}; eh = 1'b0;
      end else begin
        ed = {pkt[2*j+1], pkt[2*j]}; eh = 1'b1;
      end
      check(got_data[base+j] === ed, wide ? "R7 R4 data" : "R3 R4 data", got_data[base+j], ed);
      check(got_h[base+j] === eh, half ? "R8 validh" : "R6 R7 validh", got_h[base+j], eh);
    end
    if (half) begin
      check(last_valid_cyc == eop_cyc, "R8 half word at closing J", last_valid_cyc, eop_cyc);
      check(fall_cyc == eop_cyc + 1, "R8 active falls next clock", fall_cyc, eop_cyc + 1);
    end else begin
      check(fall_cyc == eop_cyc, "R9 active falls at closing J", fall_cyc, eop_cyc);
    end
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10 reset
    repeat (4) @(negedge clk);
    check(rx_active === 1'b0 && rx_valid === 1'b0 && rx_error === 1'b0, "R10 reset outputs",
          {29'd0, rx_active, rx_valid, rx_error}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_active === 1'b0 && rx_valid === 1'b0 && rx_error === 1'b0, "R10 after release",
          {29'd0, rx_active, rx_valid, rx_error}, 0);

    // R1 line code, unstrobed
    for (int c = 0; c < 4; c++) begin
      {dm, dp} = 2'(c);
      @(negedge clk);
      check(line_code === 2'(c), "R1 line code", line_code, c);
    end
    {dm, dp} = C_J;
    repeat (2) @(negedge clk);
    sym(C_J); sym(C_J);

    // R2 short sync ignored: two zeros then a one
    begin
      int b0;
      b0 = got_n;
      sym(C_K); sym(C_J); sym(C_J); sym(C_J);
      check(rx_active === 1'b0, "R2 short sync ignored", {31'd0, rx_active}, 0);
      check(got_n == b0, "R2 no data from short sync", got_n - b0, 0);
    end

    // narrow sweep over all byte values
    wide = 1'b0;
    for (int v = 0; v < 256; v++) begin
      pkt[0] = 8'(v);
      pkt[1] = ~8'(v);
      run_pkt(2, 0);
    end
    // long ones run: stuffing in every byte
    for (int i = 0; i < 4; i++) pkt[i] = 8'hFF;
    run_pkt(4, 0);

    // R9 dribble bits dropped
    pkt[0] = 8'hA5;
    run_pkt(1, 5);

    // wide mode: full words and half final words
    wide = 1'b1;
    for (int v = 0; v < 32; v++) begin
      for (int i = 0; i < 4; i++) pkt[i] = 8'((v * 37 + i * 91) ^ (v << 3));
      run_pkt(4, 0);
      run_pkt(3, 0);
    end
    pkt[0] = 8'h3C;
    run_pkt(1, 0);
    wide = 1'b0;
    sym(C_J);

    // R5 stuffing violation
    begin
      int b0;
      b0 = got_n;
      tx_sync();
      for (int i = 0; i < 7; i++) tx_raw(1'b1);
      check(rx_error === 1'b1, "R5 error raised", {31'd0, rx_error}, 1);
      check(rx_active === 1'b1, "R5 still active", {31'd0, rx_active}, 1);
      for (int i = 0; i < 10; i++) tx_raw(1'b0);
      check(got_n == b0, "R5 no words after error", got_n - b0, 0);
      check(rx_error === 1'b1, "R5 error held", {31'd0, rx_error}, 1);
      tx_eop();
      check(rx_error === 1'b0 && rx_active === 1'b0, "R5 cleared at EOP",
            {30'd0, rx_error, rx_active}, 0);
      check(fall_cyc == eop_cyc, "R5 active falls at J", fall_cyc, eop_cyc);
    end
    // recovery
    pkt[0] = 8'h81; pkt[1] = 8'h7E;
    run_pkt(2, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule